// File: doc/BRIEF.md
# Runtime-Configurable Recursive 8x8 Multiplier

This block multiplies two unsigned 8-bit operands. It builds the product from the bottom up. Exact 2x2 cells form each 4x4 unit, and four 4x4 units form the 8x8 result. Each partial-product bit comes from a three-in, three-out reversible-style gate, `(p, q, r) = (a, a^b, (a&b)^c)`, with `c` tied low so that `r` gives the AND term.

At each level the four sub-products are placed by the crosswise split: low·low at weight 0, the two mixed terms at weight h, and high·high at weight 2h, where h is the half-width of that level. One row of dual-mode 4:2 compressors adds them, and a carry-propagate add finishes the row. A single mode bit switches every compressor in the array between exact counting and a cheaper approximation that has no carry chain. This trades accuracy for delay while the block is running.

The operands and the mode bit are captured together when a new operation is accepted. The product appears one cycle after capture.

Top module: `vedic_mul8`

## Requirements
- R1: With `approx_i` = 0 at capture, `product_o` equals a·b for every one of the 65,536 operand pairs.
- R2: With `approx_i` = 1 at capture, `product_o` follows the approximate model.
  - Each 4:2 cell takes inputs x1..x4 from sub-product rows low·low, aH·bL, aL·bH and high·high, in that order.
  - Each cell gives sum' = (x1^x2)|(x3^x4) and carry' = (x1&x2)|(x3&x4).
  - Each cell drives its lateral carry-out to 0.
  - The 2x2 cells stay exact.
- R3: An approximate product is never larger than the true product a·b.
- R4: If either operand is zero, the product is zero in both modes.
- R5: When `valid_i` is high at clock edge k, `valid_o` is high for exactly the cycle after edge k+1. Back-to-back operations give back-to-back results.
- R6: The mode bit is sampled only with the operands. Changing `approx_i` while `valid_i` is low has no effect on a result that is in flight.
- R7: While `valid_o` is low, `product_o` keeps its last value whatever the inputs do.
- R8: Asserting `rst_ni` low clears `valid_o` and `product_o` to 0 and drops any operation in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Capture operands and mode this cycle |
| a_i | input | 8 | Multiplicand, unsigned |
| b_i | input | 8 | Multiplier, unsigned |
| approx_i | input | 1 | 1 selects approximate compression, 0 exact |
| valid_o | output | 1 | Product register holds a new result |
| product_o | output | 16 | Registered product |

## Verification
A wrong compressor cell or a misplaced sub-product alignment changes `product_o` in the very next valid result. The exhaustive exact sweep therefore exposes it on the first operand pair that excites that column. An approximation that is wrong but still plausible is caught against an independent model and by the rule that the result never exceeds the true product. A mode or valid bit held in the wrong register stage shows as a result computed in the wrong mode, or as a `valid_o` pulse one cycle off. Either one appears on the first operation after the change.

// File: rtl/vm_pkg.sv
package vm_pkg;

  typedef enum logic {
    MODE_EXACT  = 1'b0,
    MODE_APPROX = 1'b1
  } mode_e;

  typedef struct packed {
    logic p;
    logic q;
    logic r;
  } peres_t;

  // three-in three-out reversible function; r carries (a&b)^c
  function automatic peres_t peres(input logic a, input logic b, input logic c);
    peres_t t;
    t.p = a;
    t.q = a ^ b;
    t.r = (a & b) ^ c;
    return t;
  endfunction

endpackage

// File: rtl/vm_cmp42.sv
module vm_cmp42 (
  input  logic x1_i,
  input  logic x2_i,
  input  logic x3_i,
  input  logic x4_i,
  input  logic cin_i,
  input  logic approx_i,
  output logic sum_o,
  output logic carry_o,
  output logic cout_o
);
  logic s1, ex_cout, ex_sum, ex_carry;

  // exact: two chained full adders, cout independent of cin
  assign s1       = x1_i ^ x2_i ^ x3_i;
  assign ex_cout  = (x1_i & x2_i) | (x3_i & (x1_i ^ x2_i));
  assign ex_sum   = s1 ^ x4_i ^ cin_i;
  assign ex_carry = (s1 & x4_i) | (cin_i & (s1 ^ x4_i));

  always_comb begin
    if (approx_i) begin
      sum_o   = (x1_i ^ x2_i) | (x3_i ^ x4_i);
      carry_o = (x1_i & x2_i) | (x3_i & x4_i);
      cout_o  = 1'b0;
    end else begin
      sum_o   = ex_sum;
      carry_o = ex_carry;
      cout_o  = ex_cout;
    end
  end
endmodule

// File: rtl/vm_cmp_row.sv
module vm_cmp_row #(
  parameter int W = 8
) (
  input  logic [W-1:0] r0_i,
  input  logic [W-1:0] r1_i,
  input  logic [W-1:0] r2_i,
  input  logic [W-1:0] r3_i,
  input  logic         approx_i,
  output logic [W+1:0] total_o
);
  localparam int OW = W + 2;

  logic [W-1:0] s, c;
  logic [W:0]   chain;

  assign chain[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_col
    vm_cmp42 u_cmp (
      .x1_i    (r0_i[i]),
      .x2_i    (r1_i[i]),
      .x3_i    (r2_i[i]),
      .x4_i    (r3_i[i]),
      .cin_i   (chain[i]),
      .approx_i(approx_i),
      .sum_o   (s[i]),
      .carry_o (c[i]),
      .cout_o  (chain[i+1])
    );
  end

  assign total_o = OW'(s) + (OW'(c) << 1) + (OW'(chain[W]) << W);
endmodule

// File: rtl/vm_mul2.sv
module vm_mul2
  import vm_pkg::*;
(
  input  logic [1:0] a_i,
  input  logic [1:0] b_i,
  output logic [3:0] p_o
);
  logic [3:0] pp;  // pp[2*j+i] = a[i] & b[j]
  logic       c1;

  for (genvar j = 0; j < 2; j++) begin : g_row
    for (genvar i = 0; i < 2; i++) begin : g_bit
      peres_t gate;
      logic   unused_pq;
      assign gate          = peres(a_i[i], b_i[j], 1'b0);
      assign pp[2*j+i]     = gate.r;
      assign unused_pq     = gate.p ^ gate.q;
    end
  end

  assign c1     = pp[1] & pp[2];
  assign p_o[0] = pp[0];
  assign p_o[1] = pp[1] ^ pp[2];
  assign p_o[2] = pp[3] ^ c1;
  assign p_o[3] = pp[3] & c1;
endmodule

// File: rtl/vm_combine.sv
module vm_combine #(
  parameter int HW = 2
) (
  input  logic [2*HW-1:0] q_ll_i,
  input  logic [2*HW-1:0] q_hl_i,
  input  logic [2*HW-1:0] q_lh_i,
  input  logic [2*HW-1:0] q_hh_i,
  input  logic            approx_i,
  output logic [4*HW-1:0] p_o
);
  localparam int W = 4 * HW;

  logic [W-1:0] r0, r1, r2, r3;
  logic [W+1:0] total;
  logic         unused_hi;

  assign r0 = W'(q_ll_i);
  assign r1 = W'(q_hl_i) << HW;
  assign r2 = W'(q_lh_i) << HW;
  assign r3 = W'(q_hh_i) << (2 * HW);

  vm_cmp_row #(.W(W)) u_row (
    .r0_i    (r0),
    .r1_i    (r1),
    .r2_i    (r2),
    .r3_i    (r3),
    .approx_i(approx_i),
    .total_o (total)
  );

  // top bits are zero in exact mode; approximate results never exceed exact
  assign p_o       = total[W-1:0];
  assign unused_hi = ^total[W+1:W];
endmodule

// File: rtl/vm_mul4.sv
module vm_mul4 (
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  input  logic       approx_i,
  output logic [7:0] p_o
);
  logic [3:0] q [4];

  // k[0] picks the half of a, k[1] the half of b
  for (genvar k = 0; k < 4; k++) begin : g_sub
    vm_mul2 u_m2 (
      .a_i(a_i[2*(k%2)+:2]),
      .b_i(b_i[2*(k/2)+:2]),
      .p_o(q[k])
    );
  end

  vm_combine #(.HW(2)) u_comb (
    .q_ll_i  (q[0]),
    .q_hl_i  (q[1]),
    .q_lh_i  (q[2]),
    .q_hh_i  (q[3]),
    .approx_i(approx_i),
    .p_o     (p_o)
  );
endmodule

// File: rtl/vedic_mul8.sv
module vedic_mul8
  import vm_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [7:0]  a_i,
  input  logic [7:0]  b_i,
  input  logic        approx_i,
  output logic        valid_o,
  output logic [15:0] product_o
);
  localparam int OP_W   = 8;
  localparam int HALF_W = OP_W / 2;
  localparam int PR_W   = 2 * OP_W;

  logic [OP_W-1:0]   a_q, b_q;
  mode_e             mode_q;
  logic              op_vld_q, vld_q;
  logic [PR_W-1:0]   prod_d, prod_q;
  logic [OP_W-1:0]   q [4];
  logic              apx;

  assign apx = (mode_q == MODE_APPROX);

  for (genvar k = 0; k < 4; k++) begin : g_sub
    vm_mul4 u_m4 (
      .a_i     (a_q[HALF_W*(k%2)+:HALF_W]),
      .b_i     (b_q[HALF_W*(k/2)+:HALF_W]),
      .approx_i(apx),
      .p_o     (q[k])
    );
  end

  vm_combine #(.HW(HALF_W)) u_comb (
    .q_ll_i  (q[0]),
    .q_hl_i  (q[1]),
    .q_lh_i  (q[2]),
    .q_hh_i  (q[3]),
    .approx_i(apx),
    .p_o     (prod_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q      <= '0;
      b_q      <= '0;
      mode_q   <= MODE_EXACT;
      op_vld_q <= 1'b0;
      vld_q    <= 1'b0;
      prod_q   <= '0;
    end else begin
      op_vld_q <= valid_i;
      vld_q    <= op_vld_q;
      if (valid_i) begin
        a_q    <= a_i;
        b_q    <= b_i;
        mode_q <= mode_e'(approx_i);
      end
      if (op_vld_q) prod_q <= prod_d;
    end
  end

  assign valid_o   = vld_q;
  assign product_o = prod_q;
endmodule

// File: rtl/vedic_mul8_chk.sv
module vedic_mul8_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [7:0]  a_i,
  input logic [7:0]  b_i,
  input logic        approx_i,
  input logic        valid_o,
  input logic [15:0] product_o
);
  logic       v1, v2, m1, m2;
  logic [7:0] a1, b1, a2, b2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1 <= 1'b0; v2 <= 1'b0; m1 <= 1'b0; m2 <= 1'b0;
      a1 <= '0;   b1 <= '0;   a2 <= '0;   b2 <= '0;
    end else begin
      v1 <= valid_i;
      v2 <= v1;
      if (valid_i) begin a1 <= a_i; b1 <= b_i; m1 <= approx_i; end
      if (v1)      begin a2 <= a1;  b2 <= b1;  m2 <= m1;       end
    end
  end

  AST_EXACT_PRODUCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !m2) |-> (product_o == 16'(a2) * 16'(b2))) else $error("exact product wrong"); // R1

  AST_APPROX_NOT_ABOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && m2) |-> (product_o <= 16'(a2) * 16'(b2))) else $error("approx above exact"); // R3

  AST_ZERO_OPERAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (a2 == 8'd0 || b2 == 8'd0)) |-> (product_o == 16'd0)) else $error("zero operand"); // R4

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == v2) else $error("valid latency"); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(product_o)) else $error("product moved while idle"); // R7

  always @(negedge clk_i) begin
    if (!rst_ni) AST_RESET_CLEAR: assert (!valid_o && product_o == 16'd0) else $error("reset state"); // R8
  end
endmodule

bind vedic_mul8 vedic_mul8_chk u_chk (.*);

// File: tb/vedic_mul8_bench.sv
`timescale 1ns/1ps
module vedic_mul8_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  a_i = '0;
  logic [7:0]  b_i = '0;
  logic        approx_i = 1'b0;
  logic        valid_o;
  logic [15:0] product_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  vedic_mul8 u_vedic_mul8 (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .approx_i (approx_i),
    .valid_o  (valid_o),
    .product_o(product_o)
  );

  // approximate model: column counting per requirement R2
  function automatic logic [17:0] row_m(input logic [15:0] r0, input logic [15:0] r1,
                                        input logic [15:0] r2, input logic [15:0] r3,
                                        input int w, input logic apx);
    logic [17:0] acc;
    if (!apx) return 18'(r0) + 18'(r1) + 18'(r2) + 18'(r3);
    acc = '0;
    for (int i = 0; i < w; i++) begin
      logic x1, x2, x3, x4;
      x1 = r0[i]; x2 = r1[i]; x3 = r2[i]; x4 = r3[i];
      acc += 18'((x1 ^ x2) | (x3 ^ x4)) << i;
      acc += 18'((x1 & x2) | (x3 & x4)) << (i + 1);
    end
    return acc;
  endfunction

  function automatic logic [7:0] mul4_m(input logic [3:0] a, input logic [3:0] b, input logic apx);
    logic [17:0] r;
    r = row_m(16'(a[1:0]) * 16'(b[1:0]), (16'(a[3:2]) * 16'(b[1:0])) << 2,
              (16'(a[1:0]) * 16'(b[3:2])) << 2, (16'(a[3:2]) * 16'(b[3:2])) << 4, 8, apx);
    return r[7:0];
  endfunction

  function automatic logic [15:0] mul8_m(input logic [7:0] a, input logic [7:0] b, input logic apx);
    logic [17:0] r;
    r = row_m(16'(mul4_m(a[3:0], b[3:0], apx)), 16'(mul4_m(a[7:4], b[3:0], apx)) << 4,
              16'(mul4_m(a[3:0], b[7:4], apx)) << 4, 16'(mul4_m(a[7:4], b[7:4], apx)) << 8, 16, apx);
    return r[15:0];
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_tb;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic sweep(input bit apx);
    bit v1 = 1'b0, v2 = 1'b0;
    logic [7:0] a1 = '0, b1 = '0, a2 = '0, b2 = '0;
    int errs = 0;
    real rel = 0.0;
    for (int n = 0; n < 65538; n++) begin
      @(negedge clk_i);
      if (v2) begin
        logic [15:0] tru, mdl;
        tru = 16'(a2) * 16'(b2);
        mdl = mul8_m(a2, b2, apx);
        check(valid_o === 1'b1, "R5", valid_o, 1);
        if (!apx) check(product_o === tru, "R1", product_o, tru);
        else begin
          check(product_o === mdl, "R2", product_o, mdl);
          check(product_o <= tru, "R3", product_o, tru);
          if (product_o != tru) errs++;
          if (tru != 0) rel += real'(int'(tru) - int'(product_o)) / real'(tru);
        end
        if (a2 == 0 || b2 == 0) check(product_o === 16'd0, "R4", product_o, 0);
      end else begin
        check(valid_o === 1'b0, "R5", valid_o, 0);
      end
      v2 = v1; a2 = a1; b2 = b1;
      if (n < 65536) begin
        a1 = n[7:0]; b1 = n[15:8]; v1 = 1'b1;
        valid_i = 1'b1; a_i = a1; b_i = b1; approx_i = apx;
      end else begin
        v1 = 1'b0; valid_i = 1'b0;
      end
    end
    if (apx)
      $display("[TB] approx mode: error rate %0.2f%%, mean relative error %0.4f",
               100.0 * real'(errs) / 65536.0, rel / 65536.0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(valid_o === 1'b0, "R8", valid_o, 0);
    check(product_o === 16'd0, "R8", product_o, 0);
    @(negedge clk_i); #2 rst_ni = 1'b1;

    sweep(1'b0);
    sweep(1'b1);

    // R6: mode flips after capture, result stays exact
    @(negedge clk_i); valid_i = 1'b1; a_i = 8'd255; b_i = 8'd255; approx_i = 1'b0;
    @(negedge clk_i); valid_i = 1'b0; approx_i = 1'b1; a_i = 8'd3; b_i = 8'd0;
    @(negedge clk_i); check(valid_o === 1'b1 && product_o === 16'd65025, "R6", product_o, 65025);
    approx_i = 1'b0; a_i = 8'h55;
    @(negedge clk_i); check(valid_o === 1'b0 && product_o === 16'd65025, "R7", product_o, 65025);
    approx_i = 1'b1; b_i = 8'hAA;
    @(negedge clk_i); check(product_o === 16'd65025, "R7", product_o, 65025);

    // R6: approximate capture, mode drops to exact before the result
    valid_i = 1'b1; a_i = 8'd255; b_i = 8'd255; approx_i = 1'b1;
    @(negedge clk_i); valid_i = 1'b0; approx_i = 1'b0;
    @(negedge clk_i); check(product_o === mul8_m(8'd255, 8'd255, 1'b1), "R6", product_o,
                            mul8_m(8'd255, 8'd255, 1'b1));

    // R8: reset while an operation is in flight
    @(negedge clk_i); valid_i = 1'b1; a_i = 8'd200; b_i = 8'd100; approx_i = 1'b0;
    @(negedge clk_i); valid_i = 1'b0; #2 rst_ni = 1'b0;
    @(negedge clk_i); check(valid_o === 1'b0 && product_o === 16'd0, "R8", product_o, 0);
    #2 rst_ni = 1'b1;
    @(negedge clk_i); check(valid_o === 1'b0, "R8", valid_o, 0);
    @(negedge clk_i); check(product_o === 16'd0, "R8", product_o, 0);

    finish_tb;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R5: watchdog, actual timeout expected completion");
    finish_tb;
  end
endmodule